// File: doc/BRIEF.md
# SDRAM Write-to-Read Command Sequencer

This block sits on the controller side of a four-bank SDRAM with a fixed mode: a burst of four beats and a read latency of two clocks. A host hands it one request at a time over a valid/ready port. Each request carries an operation, a bank, a row, a column and, for writes, all four data beats. The sequencer keeps a record of the open row in each bank. It issues the activate or the precharge-then-activate that a request needs, and it then issues the read or write command on the clock the device can legally accept it.

The block's main feature is how a read follows a write. A read to the open row of any active bank may issue on the clock right after a write command. If the write burst is still on the bus, the write beats stop in the clock before the read and the remaining beats are never driven. A read that misses the open row of its bank waits for a precharge and an activate. Read data comes back on a separate output with a valid strobe, one beat per clock, four beats per read.

Top module: `sdram_wr_rd_seq`

## Requirements
- R1: Commands are driven on `sd_cmd` as {RAS#,CAS#,WE#}: NOP=111, ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010. A clock with no command carries NOP. ACTIVE carries the row on `sd_addr`. READ and WRITE carry the column with address bit 10 low, so there is no auto-precharge. PRECHARGE has address bit 10 low, so it applies to a single bank.
- R2: READ and WRITE go only to a bank whose open row equals the requested row. A request to an idle bank first gets an ACTIVE of its row.
- R3: A WRITE drives beat 0 in its own clock and beats 1 to 3 on the next three clocks, with `sd_dq_oe` high. A READ issued while that burst is running stops it: no write beat is driven in the READ clock or after it.
- R4: A request whose row differs from the open row of its bank produces PRECHARGE, then ACTIVE of the new row, then the READ or WRITE, to that bank in that order.
- R5: A READ to the open row of the bank just written may issue one clock after the WRITE, or at any later clock.
- R6: A READ to a different, already active bank may also issue one clock after a WRITE, and the same truncation applies.
- R7: ACTIVE follows PRECHARGE of the same bank by at least `T_RP` clocks. READ or WRITE follows ACTIVE of the same bank by at least `T_RCD` clocks.
- R8: `req_ready` is high only in a clock where the request's READ or WRITE is issued. That command appears on the SDRAM port in the following clock, and requests are served in order.
- R9: `sd_dq_oe` is low in the clock of every READ. A WRITE issues no sooner than six clocks after a READ, so the controller never drives the bus while read data is returning.
- R10: For a READ in cycle n, the device drives beat j in cycle n+2+j. The captured beat appears on `rd_data` with `rd_valid` high in cycle n+3+j, so there are four consecutive valid beats per read, in order.
- R11: `sd_dqm` is low while a write beat is driven and in the READ clock and the three clocks after it. It is high in every other clock, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Start column |
| req_wdata | input | 4*DQ_W | Write beats, beat 0 in the low bits |
| sd_cmd | output | 3 | {RAS#,CAS#,WE#} |
| sd_bank | output | 2 | Command bank |
| sd_addr | output | ROW_W | Row or column address |
| sd_dq_out | output | DQ_W | Write data to the bus |
| sd_dq_oe | output | 1 | Drive enable for write data |
| sd_dqm | output | 1 | Data mask |
| sd_dq_in | input | DQ_W | Data from the bus |
| rd_data | output | DQ_W | Captured read beat |
| rd_valid | output | 1 | Read beat strobe |

## Verification
The bench uses the default widths (16-bit data, 13-bit row, 9-bit column) and the default `T_RP` = `T_RCD` = 2. At those values a miss sequence fits in about five clocks, so a short directed run can pin down the exact spacing of precharge, activate and read. The random phase draws rows from a set of three per bank, so hits, misses and cross-bank reads right after writes all occur many times. An independent model of the bus checks the row state, the timing gaps, the truncated write beats and the returned data on every clock.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int BURST_LEN = 4;
    localparam int CAS_LAT   = 2;

    // {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } sd_cmd_e;
endpackage

// File: rtl/sdseq_bank_table.sv
module sdseq_bank_table
    import sdseq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  sd_cmd_e                           cmd_i,
    input  logic [BANK_W-1:0]                 bank_i,
    input  logic [ROW_W-1:0]                  row_i,
    output logic [NUM_BANKS-1:0]              open_o,
    output logic [NUM_BANKS-1:0]              settled_o,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]   row_o
);
    localparam int T_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TMR_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [TMR_W-1:0] tmr;
    } bank_st_t;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (st_q.tmr != '0) st_d.tmr = st_q.tmr - 1'b1;
            if (bank_i == BANK_W'(b)) begin
                if (cmd_i == CMD_PRE) begin
                    st_d.open = 1'b0;
                    st_d.tmr  = TMR_W'(T_RP - 1);
                end else if (cmd_i == CMD_ACT) begin
                    st_d.open = 1'b1;
                    st_d.row  = row_i;
                    st_d.tmr  = TMR_W'(T_RCD - 1);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign open_o[b]    = st_q.open;
        assign settled_o[b] = (st_q.tmr == '0);
        assign row_o[b]     = st_q.row;
    end
endmodule

// File: rtl/sdseq_wr_path.sv
module sdseq_wr_path
    import sdseq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      cut_i,
    input  logic [BURST_LEN*DQ_W-1:0] wdata_i,
    output logic [DQ_W-1:0]           dq_o,
    output logic                      oe_o,
    output logic                      busy_o,
    output logic                      drive_next_o
);
    localparam int CNT_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic [BURST_LEN*DQ_W-1:0] pend;
        logic [CNT_W-1:0]          left;
        logic [DQ_W-1:0]           dq;
        logic                      oe;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b0;
        if (start_i) begin
            st_d.dq   = wdata_i[DQ_W-1:0];
            st_d.oe   = 1'b1;
            st_d.pend = wdata_i >> DQ_W;
            st_d.left = CNT_W'(BURST_LEN - 1);
        end else if (cut_i) begin
            // a read takes the bus: the beats still owed are dropped
            st_d.left = '0;
        end else if (st_q.left != '0) begin
            st_d.dq   = st_q.pend[DQ_W-1:0];
            st_d.oe   = 1'b1;
            st_d.pend = st_q.pend >> DQ_W;
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_o         = st_q.dq;
    assign oe_o         = st_q.oe;
    assign busy_o       = (st_q.left != '0);
    assign drive_next_o = st_d.oe;
endmodule

// File: rtl/sdseq_rd_capture.sv
module sdseq_rd_capture
    import sdseq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic [DQ_W-1:0] data_o,
    output logic            valid_o,
    output logic            rd_hold_o,
    output logic            wr_hold_o
);
    localparam int SR_W = CAS_LAT + BURST_LEN;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [DQ_W-1:0] data;
        logic            valid;
    } rc_st_t;

    rc_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sr    = {st_q.sr[SR_W-2:0], launch_i};
        st_d.valid = |st_q.sr[SR_W-1:CAS_LAT];
        if (st_d.valid) st_d.data = dq_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o    = st_q.data;
    assign valid_o   = st_q.valid;
    // next read may follow once the previous read's four column slots pass
    assign rd_hold_o = |st_q.sr[BURST_LEN-2:0];
    // a write must wait until all returning beats have left the bus
    assign wr_hold_o = |st_q.sr[SR_W-2:0];
endmodule

// File: rtl/sdram_wr_rd_seq.sv
module sdram_wr_rd_seq
    import sdseq_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int ROW_W = 13,
    parameter int COL_W = 9,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [1:0]                req_bank,
    input  logic [ROW_W-1:0]          req_row,
    input  logic [COL_W-1:0]          req_col,
    input  logic [BURST_LEN*DQ_W-1:0] req_wdata,
    output logic [2:0]                sd_cmd,
    output logic [1:0]                sd_bank,
    output logic [ROW_W-1:0]          sd_addr,
    output logic [DQ_W-1:0]           sd_dq_out,
    output logic                      sd_dq_oe,
    output logic                      sd_dqm,
    input  logic [DQ_W-1:0]           sd_dq_in,
    output logic [DQ_W-1:0]           rd_data,
    output logic                      rd_valid
);
    // row width doubles as address width; COL_W <= 10 keeps bit 10 low
    localparam int ADDR_W = ROW_W;

    typedef struct packed {
        sd_cmd_e             cmd;
        logic [BANK_W-1:0]   bank;
        logic [ADDR_W-1:0]   addr;
        logic                dqm;
    } bus_st_t;

    bus_st_t bus_d, bus_q;

    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0]            bank_settled;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic wr_busy, wr_drive_next, rd_hold, wr_hold;
    logic hit, settled, can_rd, can_wr, can_pre, can_act, acc_rd, acc_wr;

    always_comb begin
        hit      = bank_open[req_bank] && (bank_row[req_bank] == req_row);
        settled  = bank_settled[req_bank];
        can_rd   = hit && settled && !rd_hold;
        can_wr   = hit && settled && !wr_hold && !wr_busy;
        can_pre  = bank_open[req_bank] && !hit && settled && !wr_busy && !rd_hold;
        can_act  = !bank_open[req_bank] && settled;
        req_ready = req_valid && (req_write ? can_wr : can_rd);
        acc_rd   = req_ready && !req_write;
        acc_wr   = req_ready && req_write;

        bus_d      = bus_q;
        bus_d.cmd  = CMD_NOP;
        bus_d.bank = '0;
        bus_d.addr = '0;
        if (acc_wr || acc_rd) begin
            bus_d.cmd  = acc_wr ? CMD_WR : CMD_RD;
            bus_d.bank = req_bank;
            bus_d.addr = ADDR_W'(req_col);
        end else if (req_valid && can_pre) begin
            bus_d.cmd  = CMD_PRE;
            bus_d.bank = req_bank;
        end else if (req_valid && can_act) begin
            bus_d.cmd  = CMD_ACT;
            bus_d.bank = req_bank;
            bus_d.addr = req_row;
        end
        bus_d.dqm = !(wr_drive_next || acc_rd || rd_hold);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q      <= '0;
            bus_q.cmd  <= CMD_NOP;
            bus_q.dqm  <= 1'b1;
        end else begin
            bus_q <= bus_d;
        end
    end

    sdseq_bank_table #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (bus_d.cmd),
        .bank_i    (bus_d.bank),
        .row_i     (req_row),
        .open_o    (bank_open),
        .settled_o (bank_settled),
        .row_o     (bank_row)
    );

    sdseq_wr_path #(.DQ_W(DQ_W)) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (acc_wr),
        .cut_i        (acc_rd),
        .wdata_i      (req_wdata),
        .dq_o         (sd_dq_out),
        .oe_o         (sd_dq_oe),
        .busy_o       (wr_busy),
        .drive_next_o (wr_drive_next)
    );

    sdseq_rd_capture #(.DQ_W(DQ_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (acc_rd),
        .dq_i      (sd_dq_in),
        .data_o    (rd_data),
        .valid_o   (rd_valid),
        .rd_hold_o (rd_hold),
        .wr_hold_o (wr_hold)
    );

    assign sd_cmd  = bus_q.cmd;
    assign sd_bank = bus_q.bank;
    assign sd_addr = bus_q.addr;
    assign sd_dqm  = bus_q.dqm;
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker
    import sdseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] sd_cmd,
    input logic       sd_dq_oe,
    input logic       sd_dqm,
    input logic       rd_valid
);
    logic [3:0] owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else owed_q <= owed_q + ((sd_cmd == CMD_RD) ? 4'd4 : 4'd0)
                              - (rd_valid ? 4'd1 : 4'd0);
    end

    assert_legal_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE});

    assert_wr_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_WR) |-> sd_dq_oe);

    assert_cmd_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (sd_cmd == CMD_RD || sd_cmd == CMD_WR));

    assert_rd_bus_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |-> !sd_dq_oe);

    assert_beat_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (owed_q != 4'd0));

    assert_mask_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> !sd_dqm);
endmodule

bind sdram_wr_rd_seq sdseq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sd_cmd    (sd_cmd),
    .sd_dq_oe  (sd_dq_oe),
    .sd_dqm    (sd_dqm),
    .rd_valid  (rd_valid)
);

// File: tb/tb_sdram_wr_rd_seq.sv
module tb_sdram_wr_rd_seq;
    localparam int DQ_W = 16, ROW_W = 13, COL_W = 9, T_RP = 2, T_RCD = 2;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_bank = 0;
    logic [ROW_W-1:0] req_row = 0;
    logic [COL_W-1:0] req_col = 0;
    logic [4*DQ_W-1:0] req_wdata = 0;
    logic [DQ_W-1:0] sd_dq_in = 0;
    logic req_ready, sd_dq_oe, sd_dqm, rd_valid;
    logic [2:0] sd_cmd;
    logic [1:0] sd_bank;
    logic [ROW_W-1:0] sd_addr;
    logic [DQ_W-1:0] sd_dq_out, rd_data;

    always #5 clk = ~clk;

    sdram_wr_rd_seq #(.DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid));

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] wr_beat(logic [1:0] b, logic [COL_W-1:0] c, int j);
        return {1'b1, b, c, 2'b00, 2'(j)};
    endfunction
    function automatic logic [DQ_W-1:0] rd_beat(logic [1:0] b, logic [COL_W-1:0] c, int j);
        return {1'b0, b, c, 2'b10, 2'(j)};
    endfunction

    // ---------------- bus monitor / device model ----------------
    int n = 0, wr_n = -100, rd_n = -100, wbeats = 0, rw_cmds = 0, rd_beats = 0;
    int pre_n[4] = '{-100, -100, -100, -100};
    int act_n[4] = '{-100, -100, -100, -100};
    bit open_m[4] = '{0, 0, 0, 0};
    logic [1:0] wr_bank = 0, rd_bank = 0;
    logic [COL_W-1:0] wr_col = 0;
    logic [DQ_W-1:0] sched [16];
    bit sched_v [16];
    logic [DQ_W-1:0] expq [$];

    always @(negedge clk) begin
        int k;
        logic [DQ_W-1:0] e;
        if (rst_n) begin
            n++;
            if (rd_valid) begin
                rd_beats++;
                if (expq.size() == 0) chk(0, "R10 unexpected beat", rd_data, 0);
                else begin
                    e = expq.pop_front();
                    chk(rd_data == e, "R10 read beat", rd_data, e);
                end
            end
            if (sched_v[n % 16]) begin
                sd_dq_in = sched[n % 16];
                sched_v[n % 16] = 0;
            end else sd_dq_in = '0;
            case (sd_cmd)
                C_NOP: ;
                C_ACT: begin
                    chk(!open_m[sd_bank], "R2 activate of open bank", 1, 0);
                    chk(n - pre_n[sd_bank] >= T_RP, "R7 precharge-to-activate", n - pre_n[sd_bank], T_RP);
                    open_m[sd_bank] = 1;
                    act_n[sd_bank] = n;
                end
                C_PRE: begin
                    chk(open_m[sd_bank], "R4 precharge of idle bank", 0, 1);
                    chk(sd_addr[10] == 0, "R1 precharge bit 10", sd_addr[10], 0);
                    open_m[sd_bank] = 0;
                    pre_n[sd_bank] = n;
                end
                C_WR, C_RD: begin
                    chk(open_m[sd_bank], "R2 access to idle bank", 0, 1);
                    chk(n - act_n[sd_bank] >= T_RCD, "R7 activate-to-access", n - act_n[sd_bank], T_RCD);
                    chk(sd_addr[10] == 0, "R1 column bit 10", sd_addr[10], 0);
                    rw_cmds++;
                    if (sd_cmd == C_WR) begin
                        chk(n - rd_n >= 6, "R9 write too soon after read", n - rd_n, 6);
                        wr_n = n; wbeats = 0; wr_bank = sd_bank; wr_col = sd_addr[COL_W-1:0];
                    end else begin
                        chk(!sd_dq_oe, "R9 bus driven in read clock", sd_dq_oe, 0);
                        rd_n = n; rd_bank = sd_bank;
                        for (int j = 0; j < 4; j++) begin
                            sched[(n + 2 + j) % 16] = rd_beat(sd_bank, sd_addr[COL_W-1:0], j);
                            sched_v[(n + 2 + j) % 16] = 1;
                            expq.push_back(rd_beat(sd_bank, sd_addr[COL_W-1:0], j));
                        end
                    end
                end
                default: chk(0, "R1 illegal command code", sd_cmd, C_NOP);
            endcase
            if (sd_dq_oe) begin
                k = n - wr_n;
                chk(k >= 0 && k < 4 && sd_dq_out == wr_beat(wr_bank, wr_col, k),
                    "R3 write beat", sd_dq_out, wr_beat(wr_bank, wr_col, k));
                wbeats++;
            end
            chk(sd_dqm == !(sd_dq_oe || (n - rd_n >= 0 && n - rd_n <= 3)),
                "R11 mask", sd_dqm, !(sd_dq_oe || (n - rd_n >= 0 && n - rd_n <= 3)));
        end
    end

    // ---------------- host driver ----------------
    int acc_cnt = 0, n_reads = 0;

    task automatic send(bit wr, logic [1:0] b, int r, logic [COL_W-1:0] c);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_bank = b; req_row = ROW_W'(r); req_col = c;
        req_wdata = {wr_beat(b, c, 3), wr_beat(b, c, 2), wr_beat(b, c, 1), wr_beat(b, c, 0)};
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        acc_cnt++;
        if (!wr) n_reads++;
    endtask

    task automatic idle(int cyc);
        @(negedge clk);
        req_valid = 0;
        repeat (cyc - 1) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(sd_cmd == C_NOP, "R1 reset command", sd_cmd, C_NOP);
        chk(!sd_dq_oe, "R3 reset drive", sd_dq_oe, 0);
        chk(!rd_valid, "R10 reset valid", rd_valid, 0);
        chk(sd_dqm, "R11 reset mask", sd_dqm, 1);
        chk(!req_ready, "R8 reset ready", req_ready, 0);

        // same row, read one clock after write: three beats dropped
        send(1, 0, 5, 8);
        send(0, 0, 5, 8);
        idle(10);
        chk(rd_n - wr_n == 1, "R5 read one clock after write", rd_n - wr_n, 1);
        chk(wbeats == 1, "R3 truncated beats", wbeats, 1);

        // same row, read after the full burst
        send(1, 0, 5, 16);
        idle(6);
        send(0, 0, 5, 16);
        idle(10);
        chk(wbeats == 4, "R3 full burst", wbeats, 4);
        chk(rd_n - wr_n >= 4, "R5 later read", rd_n - wr_n, 4);

        // row miss
        send(0, 0, 9, 4);
        idle(10);
        chk(pre_n[0] < act_n[0] && act_n[0] < rd_n, "R4 order", act_n[0], rd_n);
        chk(act_n[0] - pre_n[0] == T_RP, "R4 precharge-activate gap", act_n[0] - pre_n[0], T_RP);
        chk(rd_n - act_n[0] == T_RCD, "R7 activate-read gap", rd_n - act_n[0], T_RCD);

        // cross-bank read right after a write
        send(1, 1, 3, 0);
        idle(8);
        send(1, 0, 9, 1);
        send(0, 1, 3, 2);
        idle(10);
        chk(rd_n - wr_n == 1, "R6 cross-bank gap", rd_n - wr_n, 1);
        chk(rd_bank == 1, "R6 read bank", rd_bank, 1);
        chk(wbeats == 1, "R6 truncated beats", wbeats, 1);

        // idle bank gets an activate first
        send(0, 2, 7, 5);
        idle(10);
        chk(rd_bank == 2 && rd_n - act_n[2] == T_RCD, "R2 activate before read", rd_n - act_n[2], T_RCD);

        // random mix
        for (int i = 0; i < 200; i++) begin
            send(1'($urandom % 2), 2'($urandom % 4), int'($urandom % 3), COL_W'($urandom));
            if ($urandom % 3 == 0) idle(int'($urandom % 3) + 1);
        end
        idle(20);
        chk(expq.size() == 0, "R10 beats outstanding", expq.size(), 0);
        chk(rd_beats == 4 * n_reads, "R10 beat total", rd_beats, 4 * n_reads);
        chk(rw_cmds == acc_cnt, "R8 accepts vs commands", rw_cmds, acc_cnt);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule